// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers seven interrupt sources into one active-low request line. Each source delivers a one-cycle pulse that latches a sticky flag bit. A seven-bit enable mask selects which flags may raise the request. The flag register shows the raw flags in bits 6..0. Its bit 7 is a computed summary that is 1 when any flag is set and also enabled.

Software reaches the block through a small register port. It has a 4-bit register select, a write strobe, write data and combinational read data. At offset 0xD, writing 1s clears the matching flags. At offset 0xE, bit 7 of the written value decides the meaning of bits 6..0: when bit 7 is 1, each 1 sets its mask bit; when bit 7 is 0, each 1 clears its mask bit. With this convention, software can change some mask bits without reading the mask first and without disturbing the others.

The flag bits are fixed to their sources:

| Flag bit | Source |
| --- | --- |
| 6 | primary timer |
| 5 | secondary timer |
| 4 | port-B control line 1 |
| 3 | port-B control line 2 |
| 2 | shifter |
| 1 | port-A control line 1 |
| 0 | port-A control line 2 |

Top module: `irqSetClrTop`

## Requirements
- R1: A 1 on srcPulse[i] at a clock edge sets flag bit i, using the bit assignment in the table above. A flag stays set until a clear write removes it.
- R2: A write to offset 0xD clears each flag whose bit in wrData[6:0] is 1. Flags whose bit is 0 keep their value.
- R3: When a source pulse and a clear write for the same flag land on the same edge, the flag ends up set.
- R4: A write to offset 0xE with wrData[7]=1 sets each mask bit whose bit in wrData[6:0] is 1. The other mask bits keep their value.
- R5: A write to offset 0xE with wrData[7]=0 clears each mask bit whose bit in wrData[6:0] is 1. The other mask bits keep their value.
- R6: A read at offset 0xE returns 1 in bit 7 and the current mask in bits 6..0.
- R7: A read at offset 0xD returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag is both set and enabled.
- R8: irqN is 0 exactly when the summary condition of R7 holds, and 1 otherwise.
- R9: While rstN is low, all flags and all mask bits are 0 and irqN is 1.
- R10: Reads at any offset other than 0xD and 0xE return 0x00. Writes at those offsets change neither flags nor mask.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regSel (combinational) |
| srcPulse | input | 7 | Source event pulses, one per flag |
| irqN | output | 1 | Interrupt request, active low |

## Verification
Two updates can meet on the same flag in the same cycle: a source pulse that sets it and a software write to offset 0xD that clears it. A directed case drives both onto one bit, and drives a clear without a pulse onto a neighbouring bit. Afterwards the flags are read back: the pulsed bit must stay set and the neighbour must be clear. Random cycles then mix pulses with clear and mask writes freely, and every cycle's reads and irqN are compared with a bench model in which the setting pulse wins.

// File: rtl/irqSetClrPkg.sv
package irqSetClrPkg;
  typedef struct packed {
    logic flagClr;   // write to flag register: clear selected flags
    logic maskWr;    // write to enable register
    logic maskSet;   // 1: set selected mask bits, 0: clear them
    logic selFlag;   // read mux selects flag register
    logic selMask;   // read mux selects enable register
  } irqStrobe_t;
endpackage

// File: rtl/irqSetClrCtrl.sv
module irqSetClrCtrl
  import irqSetClrPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 4'hD,
  parameter logic [ADDR_W-1:0] MASK_OFS = 4'hE
) (
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic              modeBit,
  output irqStrobe_t        strobe
);
  always_comb begin
    strobe.selFlag = (regSel == FLAG_OFS);
    strobe.selMask = (regSel == MASK_OFS);
    strobe.flagClr = wrEn && strobe.selFlag;
    strobe.maskWr  = wrEn && strobe.selMask;
    strobe.maskSet = modeBit;
  end
endmodule

// File: rtl/irqSetClrData.sv
module irqSetClrData
  import irqSetClrPkg::*;
#(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] bitSel,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqN
);
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] maskNext;
  logic               anyActive;

  assign clrVec = strobe.flagClr ? bitSel : '0;

  always_comb begin
    maskNext = maskQ;
    if (strobe.maskWr) begin
      if (strobe.maskSet) maskNext = maskQ | bitSel;
      else                maskNext = maskQ & ~bitSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= (flagQ & ~clrVec) | srcPulse;  // a pulse wins over a clear
      maskQ <= maskNext;
    end
  end

  assign anyActive = |(flagQ & maskQ);
  assign irqN      = ~anyActive;

  always_comb begin
    if (strobe.selFlag)      rdData = {anyActive, flagQ};
    else if (strobe.selMask) rdData = {1'b1, maskQ};
    else                     rdData = '0;
  end
endmodule

// File: rtl/irqSetClrTop.sv
module irqSetClrTop
  import irqSetClrPkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W = 4,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regSel,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic               irqN
);
  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;

  irqSetClrCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .modeBit(wrData[DATA_W-1]),
    .strobe (strobe)
  );

  irqSetClrData #(.NUM_SRC(NUM_SRC)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitSel  (wrData[NUM_SRC-1:0]),
    .srcPulse(srcPulse),
    .flagQ   (flagQ),
    .maskQ   (maskQ),
    .rdData  (rdData),
    .irqN    (irqN)
  );
endmodule

// File: rtl/irqSetClrChk.sv
module irqSetClrChk #(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W = 4,
  localparam int DATA_W = NUM_SRC + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regSel,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_SRC-1:0] srcPulse,
  input logic               irqN,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] maskQ
);
  logic flagWr, maskWr;
  assign flagWr = wrEn && (regSel == 4'hD);
  assign maskWr = wrEn && (regSel == 4'hE);

  // R1: flags fall only through a clear write
  p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> (($past(flagQ) & ~flagQ) == '0));

  // R2: a clear write removes selected flags that are not pulsed
  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    flagWr |=> ((flagQ & $past(wrData[NUM_SRC-1:0] & ~srcPulse)) == '0));

  // R3: a pulse always leaves its flag set
  p_pulse_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|srcPulse) |=> ((flagQ & $past(srcPulse)) == $past(srcPulse)));

  // R4: set-mode mask write
  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && wrData[DATA_W-1]) |=>
      ((maskQ & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  // R5: clear-mode mask write
  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && !wrData[DATA_W-1]) |=> ((maskQ & $past(wrData[NUM_SRC-1:0])) == '0));

  // R6: enable register reads with bit 7 high
  p_mask_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 4'hE) |-> rdData[DATA_W-1]);

  // R8: summary bit and request line agree
  p_irq_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 4'hD) |-> (rdData[DATA_W-1] == !irqN));

  // R10: other offsets read as zero
  p_other_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regSel != 4'hD && regSel != 4'hE) |-> (rdData == '0));
endmodule

bind irqSetClrTop irqSetClrChk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .srcPulse(srcPulse), .irqN(irqN), .flagQ(flagQ), .maskQ(maskQ)
);

// File: tb/sim_irqSetClrTop.sv
module sim_irqSetClrTop;
  logic       clk = 0;
  logic       rstN = 0;
  logic [3:0] regSel = 0;
  logic       wrEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic [6:0] srcPulse = 0;
  logic       irqN;

  int errors = 0;
  int checks = 0;
  logic [6:0] mFlag = 0;
  logic [6:0] mMask = 0;

  always #10 clk = ~clk;  // 50 MHz

  irqSetClrTop u0 (.clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .srcPulse(srcPulse), .irqN(irqN));

  function automatic logic [7:0] expRead(input logic [3:0] s, input logic [6:0] f,
                                         input logic [6:0] m);
    if (s == 4'hD) return {|(f & m), f};
    if (s == 4'hE) return {1'b1, m};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // compare read data for current regSel and irqN against model
  task automatic compareNow(input string tag);
    #1;
    check({tag, " read"}, rdData, expRead(regSel, mFlag, mMask));
    check({tag, " R8 irqN"}, {7'b0, irqN}, {7'b0, ~|(mFlag & mMask)});
  endtask

  // apply one cycle of stimulus at negedge, update model at posedge
  task automatic cycle(input logic [3:0] s, input logic w, input logic [7:0] d,
                       input logic [6:0] p);
    @(negedge clk);
    regSel = s; wrEn = w; wrData = d; srcPulse = p;
    @(posedge clk);
    if (w && s == 4'hD) mFlag = mFlag & ~d[6:0];
    mFlag = mFlag | p;
    if (w && s == 4'hE) mMask = d[7] ? (mMask | d[6:0]) : (mMask & ~d[6:0]);
  endtask

  task automatic readAt(input logic [3:0] s, input string tag);
    @(negedge clk);
    regSel = s; wrEn = 0; srcPulse = 0;
    compareNow(tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1ce5;
    void'($urandom(seed));
    // R9: reset state
    repeat (3) @(negedge clk);
    regSel = 4'hE; #1;
    check("R9 mask at reset", rdData, 8'h80);
    regSel = 4'hD; #1;
    check("R9 flags at reset", rdData, 8'h00);
    check("R9 irqN at reset", {7'b0, irqN}, 8'h01);
    rstN = 1;

    // R1: pulses latch and hold
    cycle(4'h0, 0, 8'h00, 7'b1000001);
    cycle(4'h0, 0, 8'h00, 7'b0000000);
    readAt(4'hD, "R1 sticky flags");
    check("R1 flag value", rdData, 8'h41);
    // R4: set mask bit 6
    cycle(4'hE, 1, 8'hC0, 7'b0);
    readAt(4'hE, "R4 mask set");
    check("R6 mask read", rdData, 8'hC0);
    readAt(4'hD, "R7 summary");
    check("R7 summary set", rdData, 8'hC1);
    check("R8 irq low", {7'b0, irqN}, 8'h00);
    // R5: clear mode, zero bits untouched
    cycle(4'hE, 1, 8'h7F, 7'b0);
    cycle(4'hE, 1, 8'h85, 7'b0);
    cycle(4'hE, 1, 8'h01, 7'b0);
    readAt(4'hE, "R5 mask clear");
    check("R5 mask value", rdData, 8'h84);
    // R3: pulse on bit 2 and clear of bits 2 and 0 at once
    cycle(4'hD, 1, 8'h05, 7'b0000100);
    readAt(4'hD, "R3 collision");
    check("R3 pulse wins", rdData, 8'hC4);
    // R2: clear flag 6 only
    cycle(4'hD, 1, 8'h40, 7'b0);
    readAt(4'hD, "R2 clear");
    check("R2 flag value", rdData, 8'h84);
    // R10: writes elsewhere ignored, reads zero
    cycle(4'h3, 1, 8'hFF, 7'b0);
    cycle(4'hF, 1, 8'h7F, 7'b0);
    readAt(4'h5, "R10 other read");
    check("R10 zero", rdData, 8'h00);
    readAt(4'hD, "R10 flags kept");
    check("R10 flags", rdData, 8'h84);
    readAt(4'hE, "R10 mask kept");
    check("R10 mask", rdData, 8'h84);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      logic [6:0] p;
      int r;
      r = $urandom_range(0, 9);
      s = (r < 4) ? 4'hD : (r < 8) ? 4'hE : 4'($urandom_range(0, 15));
      p = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'b0;
      cycle(s, 1'($urandom), 8'($urandom), p);
      @(negedge clk);
      regSel = 4'($urandom_range(12, 15)); wrEn = 0; srcPulse = 0;
      compareNow("R1/R2/R3/R4/R5/R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule